// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR SDRAM from the moment its supplies and clock are stable to the point where it can accept normal traffic. Once an external power-stable indication is seen, it plays out a fixed command sequence on the four active-low control lines: a NOP, a precharge of all banks, a load of the extended mode register, a load of the mode register, and two auto-refreshes. Each command is followed by a programmed number of clocks before the next one. When the last refresh interval has passed, it raises a done flag and stays there until reset.

The contents of both mode registers are fixed at elaboration time through enumerated field parameters: burst length, burst type, CAS latency and operating mode for the mode register, and DLL enable and output drive strength for the extended mode register. The precharge/mode-load spacing, the mode-load spacing and the refresh cycle time are parameters in clocks. The command and address outputs are meant to feed the memory pins directly, or through the controller's command multiplexer, until the done flag rises.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is low, and after reset while start is low, cmd is 1111 (inhibit), addr and bank are all zero, and init_done is 0.
- R2: The first clock edge that sees start high in the idle state makes cmd 0111 (NOP) for one cycle. The cycle after that, cmd is 0010 (precharge), with addr bit 10 set and every other addr bit and bank zero.
- R3: WAIT_RP clocks after the precharge, cmd is 0000 (register load) with bank 01. The cycles in between carry NOP with zero address and bank.
- R4: During the extended register load, addr[0] is DLL_OFF (0 enables the DLL, 1 disables it), addr[1] is DRV_REDUCED (0 normal, 1 reduced drive) and all higher addr bits are 0.
- R5: WAIT_MRD clocks after the extended load, cmd is 0000 with bank 00. The cycles in between carry NOP.
- R6: During the mode register load, addr[2:0] is BURST_LEN (001 = 2, 010 = 4, 011 = 8), addr[3] is BURST_TYPE (0 sequential, 1 interleaved), addr[6:4] is CAS_LAT (010 = CL2, 110 = CL2.5, 011 = CL3), addr[8:7] is OP_MODE (00 standard) and all higher bits are 0.
- R7: WAIT_MRD clocks after the mode register load, cmd is 0001 (auto-refresh). A second 0001 follows WAIT_RFC clocks later. Every cycle in between is NOP with zero address and bank.
- R8: WAIT_RFC clocks after the second refresh, init_done becomes 1. From then until reset, init_done stays 1 and cmd stays NOP with zero address and bank.
- R9: Dropping start once the sequence has left idle has no effect on the sequence or its timing.
- R10: Asserting reset at any point in the sequence at once returns the outputs to the R1 state. The sequence then waits for start again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Power and clock stable; starts the sequence |
| cmd | output | 4 | Command {cs_n, ras_n, cas_n, we_n} |
| addr | output | A_W | Address lines, carrying register values and the all-bank flag |
| bank | output | 2 | Bank address lines |
| init_done | output | 1 | High once the memory is initialized |

## Verification
The assertions assume that the wait parameters are at least 2 clocks and that A_W is at least 11, so that bit 10 exists. The bench instances only such configurations. Start is taken to be a level that may fall at any time without harm, and reset may arrive in any state. The stimulus therefore drops start early in some runs, holds it in others, and pulses reset partway through a sequence. Three parameter sets together cover every CAS latency, burst length, burst type, DLL and drive-strength code, and use both short and long waits.

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int       A_W         = 12,
  parameter int       WAIT_RP     = 3,
  parameter int       WAIT_MRD    = 2,
  parameter int       WAIT_RFC    = 10,
  parameter bit [2:0] BURST_LEN   = 3'b011,
  parameter bit       BURST_TYPE  = 1'b0,
  parameter bit [2:0] CAS_LAT     = 3'b110,
  parameter bit [1:0] OP_MODE     = 2'b00,
  parameter bit       DLL_OFF     = 1'b0,
  parameter bit       DRV_REDUCED = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwr_ok,
  output logic [3:0]     cmd,
  output logic [A_W-1:0] addr,
  output logic [1:0]     bank,
  output logic           init_done
);

  localparam int MAXW = (WAIT_RFC > WAIT_RP) ? ((WAIT_RFC > WAIT_MRD) ? WAIT_RFC : WAIT_MRD)
                                             : ((WAIT_RP > WAIT_MRD) ? WAIT_RP : WAIT_MRD);
  localparam int CW = $clog2(MAXW + 1);

  localparam logic [3:0] S_IDLE = 4'd0,  S_NOP  = 4'd1,  S_PRE  = 4'd2,  S_WRP  = 4'd3,
                         S_EMR  = 4'd4,  S_WMRD = 4'd5,  S_MR   = 4'd6,  S_AR1  = 4'd7,
                         S_WRF1 = 4'd8,  S_AR2  = 4'd9,  S_WRF2 = 4'd10, S_RDY  = 4'd11;

  localparam logic [3:0] C_INH = 4'b1111, C_NOP = 4'b0111, C_PRE = 4'b0010,
                         C_REF = 4'b0001, C_LMR = 4'b0000;

  localparam logic [CW-1:0] L_RP  = CW'(WAIT_RP - 2);
  localparam logic [CW-1:0] L_MRD = CW'(WAIT_MRD - 2);
  localparam logic [CW-1:0] L_MR  = CW'(WAIT_MRD - 1);
  localparam logic [CW-1:0] L_RFC = CW'(WAIT_RFC - 2);

  localparam logic [A_W-1:0] MR_WORD  = A_W'({OP_MODE, CAS_LAT, BURST_TYPE, BURST_LEN});
  localparam logic [A_W-1:0] EMR_WORD = A_W'({DRV_REDUCED, DLL_OFF});
  localparam logic [A_W-1:0] ALL_BANK = A_W'(1) << 10;

  logic [3:0]    st, st_nx;
  logic [CW-1:0] cnt, cnt_ld;

  always_comb begin
    case (st)
      S_IDLE:  st_nx = pwr_ok ? S_NOP : S_IDLE;
      S_RDY:   st_nx = S_RDY;
      default: st_nx = (cnt == '0) ? st + 4'd1 : st;
    endcase
  end

  always_comb begin
    case (st_nx)
      S_WRP:          cnt_ld = L_RP;
      S_WMRD:         cnt_ld = L_MRD;
      S_MR:           cnt_ld = L_MR;
      S_WRF1, S_WRF2: cnt_ld = L_RFC;
      default:        cnt_ld = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      st <= st_nx;
      if (st_nx != st)   cnt <= cnt_ld;
      else if (cnt != 0) cnt <= cnt - 1'b1;
    end
  end

  wire mr_issue = (st == S_MR) && (cnt == L_MR);

  always_comb begin
    cmd  = C_NOP;
    addr = '0;
    bank = 2'b00;
    case (st)
      S_IDLE: cmd = C_INH;
      S_PRE: begin
        cmd  = C_PRE;
        addr = ALL_BANK;
      end
      S_EMR: begin
        cmd  = C_LMR;
        addr = EMR_WORD;
        bank = 2'b01;
      end
      S_MR: if (mr_issue) begin
        cmd  = C_LMR;
        addr = MR_WORD;
      end
      S_AR1, S_AR2: cmd = C_REF;
      default: ;
    endcase
  end

  assign init_done = (st == S_RDY);

endmodule

module ddr_init_chk #(
  parameter int A_W = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pwr_ok,
  input logic [3:0]     cmd,
  input logic [A_W-1:0] addr,
  input logic [1:0]     bank,
  input logic           init_done
);
  AST_IDLE_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
                    (cmd == 4'b1111 && !pwr_ok) |=> (cmd == 4'b1111 && !init_done)); // R1
  AST_PRE_ALLBANK: assert property (@(posedge clk) disable iff (!rst_n)
                    (cmd == 4'b0010) |-> (addr[10] && bank == 2'b00)); // R2
  AST_LMR_BANK:   assert property (@(posedge clk) disable iff (!rst_n)
                    (cmd == 4'b0000) |-> (bank == 2'b00 || bank == 2'b01)); // R3
  AST_EMR_HIGHZERO: assert property (@(posedge clk) disable iff (!rst_n)
                    (cmd == 4'b0000 && bank == 2'b01) |-> (addr[A_W-1:2] == '0)); // R4
  AST_MR_HIGHZERO: assert property (@(posedge clk) disable iff (!rst_n)
                    (cmd == 4'b0000 && bank == 2'b00) |-> (addr[A_W-1:9] == '0)); // R6
  AST_REF_THEN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
                    (cmd == 4'b0001) |=> (cmd == 4'b0111)); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                    init_done |=> init_done); // R8
  AST_DONE_NOP:   assert property (@(posedge clk) disable iff (!rst_n)
                    init_done |-> (cmd == 4'b0111 && addr == '0 && bank == 2'b00)); // R8
endmodule

bind ddr_init_seq ddr_init_chk #(.A_W(A_W)) u_chk (.*);

// File: tb/sim_ddr_init_seq.sv
module sim_ddr_init_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  logic [3:0]  c0, c1, c2;
  logic [11:0] a0, a1, a2;
  logic [1:0]  b0, b1, b2;
  logic        d0, d1, d2;

  ddr_init_seq u0 (.clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
                   .cmd(c0), .addr(a0), .bank(b0), .init_done(d0));
  ddr_init_seq #(.WAIT_RP(2), .WAIT_MRD(3), .WAIT_RFC(4), .BURST_LEN(3'b010), .BURST_TYPE(1'b1),
                 .CAS_LAT(3'b010), .DLL_OFF(1'b1), .DRV_REDUCED(1'b1))
    u1 (.clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
        .cmd(c1), .addr(a1), .bank(b1), .init_done(d1));
  ddr_init_seq #(.BURST_LEN(3'b001), .CAS_LAT(3'b011))
    u2 (.clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok),
        .cmd(c2), .addr(a2), .bank(b2), .init_done(d2));

  wire [18:0] got0 = {d0, b0, a0, c0};
  wire [18:0] got1 = {d1, b1, a1, c1};
  wire [18:0] got2 = {d2, b2, a2, c2};

  localparam logic [18:0] IDLE_V = {1'b0, 2'b00, 12'h000, 4'b1111};

  function automatic logic [18:0] expv(int k, int rp, int mrd, int rfc,
                                       logic [11:0] emr, logic [11:0] mr);
    int pe, pm, p1, p2, pd;
    pe = 1 + rp; pm = pe + mrd; p1 = pm + mrd; p2 = p1 + rfc; pd = p2 + rfc;
    if (k == 1)       return {1'b0, 2'b00, 12'h400, 4'b0010};
    if (k == pe)      return {1'b0, 2'b01, emr, 4'b0000};
    if (k == pm)      return {1'b0, 2'b00, mr, 4'b0000};
    if (k == p1 || k == p2) return {1'b0, 2'b00, 12'h000, 4'b0001};
    if (k >= pd)      return {1'b1, 2'b00, 12'h000, 4'b0111};
    return {1'b0, 2'b00, 12'h000, 4'b0111};
  endfunction

  function automatic string reqv(int k, int rp, int mrd, int rfc);
    int pe, pm, p1, pd;
    pe = 1 + rp; pm = pe + mrd; p1 = pm + mrd; pd = p1 + 2 * rfc;
    if (k <= 1)  return "R2";
    if (k < pe)  return "R3";
    if (k == pe) return "R4";
    if (k < pm)  return "R5";
    if (k == pm) return "R6";
    if (k < pd)  return (k < p1) ? "R5" : "R7";
    return "R8";
  endfunction

  task automatic chk(string req, logic [18:0] got, logic [18:0] exp, int unit, int k);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s u%0d k=%0d got=%h exp=%h", req, unit, k, got, exp);
    end
  endtask

  task automatic chk_idle(string req);
    chk(req, got0, IDLE_V, 0, -1);
    chk(req, got1, IDLE_V, 1, -1);
    chk(req, got2, IDLE_V, 2, -1);
  endtask

  // start already driven high; steps k = 0..len-1, drop start at k==drop, reset at k==abort
  task automatic run(int len, int drop, int abort);
    for (int k = 0; k < len; k++) begin
      @(posedge clk); #1;
      if (k == abort) begin
        rst_n = 1'b0; pwr_ok = 1'b0; #1;
        chk_idle("R10");
        for (int i = 0; i < 3; i++) begin @(posedge clk); #1; chk_idle("R10"); end
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin @(posedge clk); #1; chk_idle("R10"); end
        return;
      end
      chk((k > drop) ? "R9" : reqv(k, 3, 2, 10), got0,
          expv(k, 3, 2, 10, 12'h000, 12'h063), 0, k);
      chk((k > drop) ? "R9" : reqv(k, 2, 3, 4), got1,
          expv(k, 2, 3, 4, 12'h003, 12'h02A), 1, k);
      chk((k > drop) ? "R9" : reqv(k, 3, 2, 10), got2,
          expv(k, 3, 2, 10, 12'h000, 12'h031), 2, k);
      if (k == drop) pwr_ok = 1'b0;
    end
  endtask

  initial begin
    #1;
    chk_idle("R1");
    repeat (3) @(posedge clk);
    #1 chk_idle("R1");
    rst_n = 1'b1;
    for (int dly = 0; dly < 4; dly++) begin
      for (int i = 0; i < dly; i++) begin @(posedge clk); #1; chk_idle("R1"); end
      pwr_ok = 1'b1;
      run(40, (dly == 1) ? 2 : 1000, 1000);
      rst_n = 1'b0; pwr_ok = 1'b0; #1;
      chk_idle("R10");
      @(posedge clk); #1;
      rst_n = 1'b1;
    end
    for (int ab = 3; ab < 24; ab += 5) begin
      pwr_ok = 1'b1;
      run(40, 1000, ab);
    end
    pwr_ok = 1'b1;
    run(45, 0, 1000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule